// File: doc/BRIEF.md
# Coalescing Write Buffer with Fence Epochs

This block sits between a core's store pipeline and the memory side. It holds stores as whole 32-byte blocks. A store whose block is already held in the current fence epoch is folded into that slot, even if other stores were accepted in between. Slots leave the buffer in any order, so stores to different blocks become visible in an order that need not match program order. A fence splits the store stream into epochs. A slot opened after a fence never absorbs a later store into an earlier epoch's slot, and it never drains while a slot from an older epoch is still held.

Each slot is a two-state machine. `SLOT_FREE` moves to `SLOT_HELD` when a store is allocated to it. `SLOT_HELD` returns to `SLOT_FREE` when its drain handshake completes. The drain channel is also a two-state machine. In `DRN_IDLE` it scans, round-robin from just past the last slot it drained, for a held slot whose epoch is the oldest one present. When it finds one, it latches that slot and moves to `DRN_OFFER`. In `DRN_OFFER` it presents the slot and returns to `DRN_IDLE` on the cycle `dr_ready` is high. The epoch counter advances on a fence only when the current epoch owns at least one slot. The oldest-epoch pointer steps forward one per cycle while no slot carries its value.

Top module: `coalesce_wbuf`

## Requirements
- R1: After reset, `empty` is 1, `dr_valid` is 0 and `st_ready` is 1.
- R2: A store is merged into a slot when the slot holds the same block address and belongs to the current epoch, and that slot is not being offered. In a merge, the bytes whose `st_be` bit is set take the new data, the other bytes keep their contents, and the mask becomes the OR of the old mask and `st_be`. The merged block leaves in a single drain transfer.
- R3: Stores to the same block merge even when stores to other blocks were accepted between them.
- R4: While `dr_valid` is high and `dr_ready` is low, `dr_valid`, `dr_blk`, `dr_data` and `dr_mask` hold their values. `dr_mask` bit i marks byte i, which is `dr_data[8i+7:8i]`.
- R5: A drained slot always belongs to the oldest epoch still held. Slots within one epoch may drain in any order.
- R6: A store issued after a fence to a block held from before that fence opens a new slot and does not merge.
- R7: A store accepted in the same cycle as a fence belongs to the epoch before that fence.
- R8: When all 4 slots are held and the store matches no slot of the current epoch, `st_ready` is 0. Otherwise a store with no match is accepted.
- R9: A store whose matching slot is the one currently offered on the drain port sees `st_ready` 0 until that transfer completes.
- R10: `empty` is 1 exactly when no slot is held. It goes to 0 the cycle after a store is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| st_valid | input | 1 | Store request present |
| st_ready | output | 1 | Store can be taken this cycle |
| st_blk | input | BADDR_W (27) | Block address of the store |
| st_be | input | NBYTES (32) | Byte enables, bit i for byte i |
| st_data | input | 8*NBYTES (256) | Store data, byte i at bits 8i+7:8i |
| fence | input | 1 | Fence pulse, ordered after a store in the same cycle |
| dr_valid | output | 1 | A block is offered to memory |
| dr_ready | input | 1 | Memory takes the offered block |
| dr_blk | output | BADDR_W (27) | Block address being drained |
| dr_data | output | 8*NBYTES (256) | Block data being drained |
| dr_mask | output | NBYTES (32) | Valid bytes of the drained block |
| empty | output | 1 | No slot is held |

## Verification
The hardest overlap is a store that targets the very slot the drain port is offering, or a store arriving on the same cycle that another slot completes its handshake. The random phase provokes both by mixing a small pool of block addresses with a `dr_ready` that toggles at random. The bench predicts `st_ready` every cycle from its own model of held slots, including the slot that `dr_blk` points to. The same overlap occurs between a fence and a store on one cycle. It is judged by the count, order and mask of the drains that follow for that block.

// File: rtl/cwb_pkg.sv
package cwb_pkg;

    typedef enum logic {
        SLOT_FREE,
        SLOT_HELD
    } slot_state_e;

    typedef enum logic {
        DRN_IDLE,
        DRN_OFFER
    } drn_state_e;

endpackage

// File: rtl/cwb_slot.sv
module cwb_slot
    import cwb_pkg::*;
#(
    parameter int BADDR_W = 27,
    parameter int NBYTES  = 32,
    parameter int EP_W    = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  alloc_i,
    input  logic                  merge_i,
    input  logic                  release_i,
    input  logic [BADDR_W-1:0]    st_blk_i,
    input  logic [NBYTES-1:0]     st_be_i,
    input  logic [NBYTES*8-1:0]   st_data_i,
    input  logic [EP_W-1:0]       cur_ep_i,
    output logic                  held_o,
    output logic                  hit_o,
    output logic [BADDR_W-1:0]    blk_o,
    output logic [EP_W-1:0]       ep_o,
    output logic [NBYTES-1:0]     mask_o,
    output logic [NBYTES*8-1:0]   data_o
);

    slot_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SLOT_FREE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_FREE: if (alloc_i)   state_d = SLOT_HELD;
            SLOT_HELD: if (release_i) state_d = SLOT_FREE;
        endcase
    end

    always_comb begin
        held_o = (state_q == SLOT_HELD);
        hit_o  = held_o && (blk_o == st_blk_i) && (ep_o == cur_ep_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            blk_o  <= '0;
            ep_o   <= '0;
            mask_o <= '0;
        end else if (alloc_i) begin
            blk_o  <= st_blk_i;
            ep_o   <= cur_ep_i;
            mask_o <= st_be_i;
        end else if (merge_i) begin
            mask_o <= mask_o | st_be_i;
        end
    end

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                data_o[8*b +: 8] <= 8'h00;
            else if (alloc_i)
                data_o[8*b +: 8] <= st_be_i[b] ? st_data_i[8*b +: 8] : 8'h00;
            else if (merge_i && st_be_i[b])
                data_o[8*b +: 8] <= st_data_i[8*b +: 8];
        end
    end

endmodule

// File: rtl/cwb_epoch.sv
module cwb_epoch #(
    parameter int N    = 4,
    parameter int EP_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     fence_i,
    input  logic                     alloc_any_i,
    input  logic [N-1:0]             held_i,
    input  logic [N-1:0][EP_W-1:0]   ep_i,
    output logic [EP_W-1:0]          cur_o,
    output logic [EP_W-1:0]          head_o
);

    logic cur_used, head_used;

    always_comb begin
        cur_used  = alloc_any_i;
        head_used = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (held_i[i] && ep_i[i] == cur_o)  cur_used  = 1'b1;
            if (held_i[i] && ep_i[i] == head_o) head_used = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_o  <= '0;
            head_o <= '0;
        end else begin
            if (fence_i && cur_used)
                cur_o <= cur_o + 1'b1;
            if (!head_used && head_o != cur_o)
                head_o <= head_o + 1'b1;
        end
    end

endmodule

// File: rtl/cwb_drain.sv
module cwb_drain
    import cwb_pkg::*;
#(
    parameter int N     = 4,
    parameter int IDX_W = 2,
    parameter int EP_W  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N-1:0]             held_i,
    input  logic [N-1:0][EP_W-1:0]   ep_i,
    input  logic [EP_W-1:0]          head_i,
    input  logic                     dr_ready_i,
    output logic                     dr_valid_o,
    output logic [IDX_W-1:0]         sel_o,
    output logic [N-1:0]             release_o
);

    drn_state_e       state_q, state_d;
    logic [IDX_W-1:0] rr_q, rr_d;
    logic [IDX_W-1:0] sel_d;
    logic [IDX_W-1:0] pick_idx;
    logic             pick_ok;
    logic [N-1:0]     elig;

    always_comb begin
        for (int i = 0; i < N; i++)
            elig[i] = held_i[i] && (ep_i[i] == head_i);
        pick_ok  = 1'b0;
        pick_idx = '0;
        for (int k = 0; k < N; k++) begin
            int j;
            j = int'(rr_q) + k;
            if (j >= N) j = j - N;
            if (!pick_ok && elig[j]) begin
                pick_ok  = 1'b1;
                pick_idx = IDX_W'(j);
            end
        end
    end

    always_comb begin
        state_d = state_q;
        sel_d   = sel_o;
        rr_d    = rr_q;
        unique case (state_q)
            DRN_IDLE: begin
                if (pick_ok) begin
                    state_d = DRN_OFFER;
                    sel_d   = pick_idx;
                end
            end
            DRN_OFFER: begin
                if (dr_ready_i) begin
                    state_d = DRN_IDLE;
                    rr_d    = (int'(sel_o) == N - 1) ? '0 : sel_o + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DRN_IDLE;
            sel_o   <= '0;
            rr_q    <= '0;
        end else begin
            state_q <= state_d;
            sel_o   <= sel_d;
            rr_q    <= rr_d;
        end
    end

    always_comb begin
        dr_valid_o = (state_q == DRN_OFFER);
        release_o  = '0;
        if (dr_valid_o && dr_ready_i)
            release_o[sel_o] = 1'b1;
    end

endmodule

// File: rtl/coalesce_wbuf.sv
module coalesce_wbuf
    import cwb_pkg::*;
#(
    parameter int NUM_ENT = 4,
    parameter int NBYTES  = 32,
    parameter int BADDR_W = 27
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  st_valid,
    output logic                  st_ready,
    input  logic [BADDR_W-1:0]    st_blk,
    input  logic [NBYTES-1:0]     st_be,
    input  logic [NBYTES*8-1:0]   st_data,
    input  logic                  fence,
    output logic                  dr_valid,
    input  logic                  dr_ready,
    output logic [BADDR_W-1:0]    dr_blk,
    output logic [NBYTES*8-1:0]   dr_data,
    output logic [NBYTES-1:0]     dr_mask,
    output logic                  empty
);

    localparam int IDX_W  = $clog2(NUM_ENT);
    localparam int EP_W   = $clog2(NUM_ENT + 1) + 1;
    localparam int DATA_W = NBYTES * 8;

    logic [NUM_ENT-1:0]             held_q, hit_vec, alloc_vec, merge_vec, rel_vec;
    logic [NUM_ENT-1:0][EP_W-1:0]   ep_q;
    logic [BADDR_W-1:0]             blk_q  [NUM_ENT];
    logic [NBYTES-1:0]              mask_q [NUM_ENT];
    logic [DATA_W-1:0]              data_q [NUM_ENT];
    logic [EP_W-1:0]                cur_ep, head_ep;
    logic [IDX_W-1:0]               sel_idx, hit_idx, free_idx;
    logic                           hit_any, free_any, accept, locked;

    for (genvar g = 0; g < NUM_ENT; g++) begin : g_slot
        cwb_slot #(
            .BADDR_W (BADDR_W),
            .NBYTES  (NBYTES),
            .EP_W    (EP_W)
        ) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .alloc_i   (alloc_vec[g]),
            .merge_i   (merge_vec[g]),
            .release_i (rel_vec[g]),
            .st_blk_i  (st_blk),
            .st_be_i   (st_be),
            .st_data_i (st_data),
            .cur_ep_i  (cur_ep),
            .held_o    (held_q[g]),
            .hit_o     (hit_vec[g]),
            .blk_o     (blk_q[g]),
            .ep_o      (ep_q[g]),
            .mask_o    (mask_q[g]),
            .data_o    (data_q[g])
        );
    end

    cwb_epoch #(
        .N    (NUM_ENT),
        .EP_W (EP_W)
    ) u_epoch (
        .clk         (clk),
        .rst_n       (rst_n),
        .fence_i     (fence),
        .alloc_any_i (|alloc_vec),
        .held_i      (held_q),
        .ep_i        (ep_q),
        .cur_o       (cur_ep),
        .head_o      (head_ep)
    );

    cwb_drain #(
        .N     (NUM_ENT),
        .IDX_W (IDX_W),
        .EP_W  (EP_W)
    ) u_drain (
        .clk        (clk),
        .rst_n      (rst_n),
        .held_i     (held_q),
        .ep_i       (ep_q),
        .head_i     (head_ep),
        .dr_ready_i (dr_ready),
        .dr_valid_o (dr_valid),
        .sel_o      (sel_idx),
        .release_o  (rel_vec)
    );

    always_comb begin
        hit_any  = 1'b0;
        hit_idx  = '0;
        free_any = 1'b0;
        free_idx = '0;
        for (int i = 0; i < NUM_ENT; i++) begin
            if (!hit_any && hit_vec[i]) begin
                hit_any = 1'b1;
                hit_idx = IDX_W'(i);
            end
            if (!free_any && !held_q[i]) begin
                free_any = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end

    always_comb begin
        locked   = dr_valid && (sel_idx == hit_idx);
        st_ready = hit_any ? !locked : free_any;
        accept   = st_valid && st_ready;
        for (int i = 0; i < NUM_ENT; i++) begin
            merge_vec[i] = accept &&  hit_any && (hit_idx  == IDX_W'(i));
            alloc_vec[i] = accept && !hit_any && (free_idx == IDX_W'(i));
        end
    end

    always_comb begin
        dr_blk  = blk_q[sel_idx];
        dr_data = data_q[sel_idx];
        dr_mask = mask_q[sel_idx];
        empty   = ~|held_q;
    end

endmodule

// File: rtl/cwb_chk.sv
module cwb_chk #(
    parameter int N       = 4,
    parameter int NBYTES  = 32,
    parameter int BADDR_W = 27,
    parameter int EP_W    = 4,
    parameter int IDX_W   = 2
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   st_valid,
    input logic                   st_ready,
    input logic                   dr_valid,
    input logic                   dr_ready,
    input logic [BADDR_W-1:0]     dr_blk,
    input logic [NBYTES*8-1:0]    dr_data,
    input logic [NBYTES-1:0]      dr_mask,
    input logic                   empty,
    input logic [N-1:0]           held_q,
    input logic                   hit_any,
    input logic [IDX_W-1:0]       sel_idx,
    input logic [N-1:0][EP_W-1:0] ep_q,
    input logic [EP_W-1:0]        head_ep
);

    // R4
    drain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dr_valid && !dr_ready |=> dr_valid && $stable(dr_blk) && $stable(dr_data) && $stable(dr_mask));

    // R10
    empty_no_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !dr_valid && st_ready);

    // R10
    store_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid && st_ready |=> !empty);

    // R8
    full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&held_q) && !hit_any |-> !st_ready);

    // R5
    oldest_epoch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dr_valid |-> held_q[sel_idx] && (ep_q[sel_idx] == head_ep));

endmodule

bind coalesce_wbuf cwb_chk #(
    .N       (NUM_ENT),
    .NBYTES  (NBYTES),
    .BADDR_W (BADDR_W),
    .EP_W    (EP_W),
    .IDX_W   (IDX_W)
) u_cwb_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .st_valid (st_valid),
    .st_ready (st_ready),
    .dr_valid (dr_valid),
    .dr_ready (dr_ready),
    .dr_blk   (dr_blk),
    .dr_data  (dr_data),
    .dr_mask  (dr_mask),
    .empty    (empty),
    .held_q   (held_q),
    .hit_any  (hit_any),
    .sel_idx  (sel_idx),
    .ep_q     (ep_q),
    .head_ep  (head_ep)
);

// File: tb/tb_coalesce_wbuf.sv
`timescale 1ns/1ps
module tb_coalesce_wbuf;

    localparam int NE = 4;
    localparam int NB = 32;
    localparam int AW = 27;
    localparam int MM = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           st_valid = 1'b0, st_ready;
    logic [AW-1:0]  st_blk = '0;
    logic [NB-1:0]  st_be = '0;
    logic [NB*8-1:0] st_data = '0;
    logic           fence = 1'b0;
    logic           dr_valid, dr_ready = 1'b0;
    logic [AW-1:0]  dr_blk;
    logic [NB*8-1:0] dr_data;
    logic [NB-1:0]  dr_mask;
    logic           empty;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    coalesce_wbuf #(.NUM_ENT(NE), .NBYTES(NB), .BADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
        .st_blk(st_blk), .st_be(st_be), .st_data(st_data), .fence(fence),
        .dr_valid(dr_valid), .dr_ready(dr_ready), .dr_blk(dr_blk),
        .dr_data(dr_data), .dr_mask(dr_mask), .empty(empty)
    );

    // reference model of held slots
    bit             m_vld  [MM];
    logic [AW-1:0]  m_blk  [MM];
    int             m_gen  [MM];
    logic [NB-1:0]  m_mask [MM];
    logic [NB*8-1:0] m_data [MM];
    int             cur_gen = 0;

    // per-phase watch on one block
    logic [AW-1:0]  w_blk = '1;
    int             w_cnt = 0;
    logic [NB-1:0]  w_first = '0;

    // previous-cycle drain sample for R4
    bit             p_hold = 1'b0;
    logic [AW-1:0]  p_blk;
    logic [NB*8-1:0] p_data;
    logic [NB-1:0]  p_mask;

    function automatic int m_count();
        int c = 0;
        for (int i = 0; i < MM; i++) if (m_vld[i]) c++;
        return c;
    endfunction

    function automatic int min_gen();
        int g = 32'h7fffffff;
        for (int i = 0; i < MM; i++) if (m_vld[i] && m_gen[i] < g) g = m_gen[i];
        return g;
    endfunction

    function automatic int find_hit(logic [AW-1:0] b);
        for (int i = 0; i < MM; i++)
            if (m_vld[i] && m_blk[i] == b && m_gen[i] == cur_gen) return i;
        return -1;
    endfunction

    function automatic logic [NB*8-1:0] expand(logic [NB-1:0] m);
        logic [NB*8-1:0] r;
        for (int i = 0; i < NB; i++) r[8*i +: 8] = {8{m[i]}};
        return r;
    endfunction

    task automatic check(bit ok, string tag, logic [255:0] act, logic [255:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_store(logic [AW-1:0] b, logic [NB-1:0] be, logic [NB*8-1:0] d);
        int h;
        h = find_hit(b);
        if (h >= 0) begin
            m_data[h] = (m_data[h] & ~expand(be)) | (d & expand(be));
            m_mask[h] = m_mask[h] | be;
        end else begin
            for (int i = 0; i < MM; i++) begin
                if (!m_vld[i]) begin
                    m_vld[i] = 1'b1; m_blk[i] = b; m_gen[i] = cur_gen;
                    m_mask[i] = be; m_data[i] = d & expand(be);
                    break;
                end
            end
        end
    endtask

    task automatic model_drain(logic [AW-1:0] b, logic [NB*8-1:0] d, logic [NB-1:0] m);
        int f = -1;
        int g;
        g = min_gen();
        for (int i = 0; i < MM; i++)
            if (m_vld[i] && m_blk[i] == b && m_gen[i] == g) f = i;
        // R5: drained block must be held in the oldest epoch
        check(f >= 0, "R5 drained block not in oldest epoch", 256'(b), 256'(g));
        if (f >= 0) begin
            // R2: merged mask and data
            check(m == m_mask[f], "R2 drain mask", 256'(m), 256'(m_mask[f]));
            check((d & expand(m)) == m_data[f], "R2 drain data", d & expand(m), m_data[f]);
            m_vld[f] = 1'b0;
        end
        if (b == w_blk) begin
            if (w_cnt == 0) w_first = m;
            w_cnt++;
        end
    endtask

    task automatic step(bit sv, logic [AW-1:0] b, logic [NB-1:0] be,
                        logic [NB*8-1:0] d, bit fn, bit rdy);
        int h;
        bit lk, exp_rdy, s_rdy, s_dv;
        logic [AW-1:0] s_blk;
        logic [NB*8-1:0] s_data;
        logic [NB-1:0] s_mask;
        string tag;
        @(negedge clk);
        st_valid = sv; st_blk = b; st_be = be; st_data = d; fence = fn; dr_ready = rdy;
        #1;
        h  = find_hit(b);
        lk = (h >= 0) && dr_valid && (dr_blk == b) && (m_gen[h] == min_gen());
        exp_rdy = (h >= 0) ? !lk : (m_count() < NE);
        if (sv) begin
            tag = (h >= 0) ? (lk ? "R9 stall on offered slot" : "R2 merge accept")
                           : "R8 capacity";
            check(st_ready == exp_rdy, tag, 256'(st_ready), 256'(exp_rdy));
        end
        // R10
        check(empty == (m_count() == 0), "R10 empty flag", 256'(empty), 256'(m_count() == 0));
        // R4
        if (p_hold)
            check(dr_valid && dr_blk == p_blk && dr_data == p_data && dr_mask == p_mask,
                  "R4 drain hold", 256'(dr_blk), 256'(p_blk));
        s_rdy = st_ready; s_dv = dr_valid;
        s_blk = dr_blk; s_data = dr_data; s_mask = dr_mask;
        @(posedge clk);
        if (s_dv && rdy) model_drain(s_blk, s_data, s_mask);
        if (sv && s_rdy) model_store(b, be, d);
        if (fn) cur_gen++;
        p_hold = s_dv && !rdy;
        p_blk = s_blk; p_data = s_data; p_mask = s_mask;
    endtask

    task automatic idle(bit rdy);
        step(1'b0, '0, '0, '0, 1'b0, rdy);
    endtask

    task automatic flush();
        for (int i = 0; i < 60; i++) begin
            if (m_count() == 0 && empty) break;
            idle(1'b1);
        end
    endtask

    function automatic logic [NB*8-1:0] rdata();
        return {$urandom(), $urandom(), $urandom(), $urandom(),
                $urandom(), $urandom(), $urandom(), $urandom()};
    endfunction

    initial begin
        #200000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] lb;
        void'($urandom(32'd20240611));
        for (int i = 0; i < MM; i++) m_vld[i] = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1
        check(empty == 1'b1, "R1 reset empty", 256'(empty), 256'(1));
        check(dr_valid == 1'b0, "R1 reset dr_valid", 256'(dr_valid), 256'(0));
        check(st_ready == 1'b1, "R1 reset st_ready", 256'(st_ready), 256'(1));
        rst_n = 1'b1;
        idle(1'b0);

        // R3: A and A with B between, C first so that C is the offered slot
        w_blk = 27'h0A; w_cnt = 0;
        step(1, 27'h0C, 32'hFFFF_FFFF, rdata(), 0, 0);
        step(1, 27'h0A, 32'h0000_000F, rdata(), 0, 0);
        step(1, 27'h0B, 32'h0000_00F0, rdata(), 0, 0);
        step(1, 27'h0A, 32'h0000_0F00, rdata(), 0, 0);
        flush();
        check(w_cnt == 1, "R3 single drain for merged block", 256'(w_cnt), 256'(1));
        check(w_first == 32'h0000_0F0F, "R3 merged mask", 256'(w_first), 256'(32'h0F0F));

        // R7: store and fence together, then same block again
        w_blk = 27'h11; w_cnt = 0;
        step(1, 27'h11, 32'h0000_000F, rdata(), 1, 0);
        step(1, 27'h11, 32'h0000_00F0, rdata(), 0, 0);
        flush();
        check(w_cnt == 2, "R7 fence splits same-cycle store", 256'(w_cnt), 256'(2));
        check(w_first == 32'h0000_000F, "R7 older store drains first", 256'(w_first), 256'(32'hF));

        // R6: store, fence alone, store to same block
        w_blk = 27'h12; w_cnt = 0;
        step(1, 27'h12, 32'h0000_0003, rdata(), 0, 0);
        step(0, '0, '0, '0, 1, 0);
        step(1, 27'h12, 32'h0000_000C, rdata(), 0, 0);
        flush();
        check(w_cnt == 2, "R6 no merge across fence", 256'(w_cnt), 256'(2));
        check(w_first == 32'h0000_0003, "R6 pre-fence slot first", 256'(w_first), 256'(32'h3));

        // R5: two epochs, newer epoch filled first in slot order
        step(1, 27'h21, 32'h1, rdata(), 0, 0);
        step(1, 27'h22, 32'h1, rdata(), 1, 0);
        step(1, 27'h23, 32'h1, rdata(), 0, 0);
        step(1, 27'h24, 32'h1, rdata(), 0, 0);
        flush();

        // R8 and R9: fill, overflow, merge into non-offered, store to offered
        step(1, 27'h31, 32'h1, rdata(), 0, 0);
        step(1, 27'h32, 32'h1, rdata(), 0, 0);
        step(1, 27'h33, 32'h1, rdata(), 0, 0);
        step(1, 27'h34, 32'h1, rdata(), 0, 0);
        step(1, 27'h35, 32'h1, rdata(), 0, 0);
        lb = dr_blk;
        step(1, (lb == 27'h33) ? 27'h32 : 27'h33, 32'h2, rdata(), 0, 0);
        step(1, lb, 32'h4, rdata(), 0, 0);
        step(1, lb, 32'h4, rdata(), 0, 1);
        flush();

        // random phase
        for (int n = 0; n < 4000; n++) begin
            logic [NB-1:0] be;
            be = ($urandom_range(0, 3) == 0) ? '1 : NB'($urandom());
            step($urandom_range(0, 9) < 6, AW'(27'h40 + $urandom_range(0, 4)), be,
                 rdata(), $urandom_range(0, 11) == 0, $urandom_range(0, 1) == 1);
        end
        flush();
        // R10
        check(empty == 1'b1, "R10 empty after flush", 256'(empty), 256'(1));

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule